// File: doc/BRIEF.md
# DRAM Initialization Command Sequencer

This block plays out a short list of raw DRAM commands at power-up, before the memory controller is allowed to carry normal traffic. Software fills up to sixteen slots. Each slot holds two words. The first is a command word that gives the levels of the chip-select, row-strobe, column-strobe, write-enable and clock-enable pins and the bank bits. The second is a parameter word that gives the 11-bit address or mode value and the wait that must follow the command.

Software then sets a valid flag and the index of the last slot in the issue register, and sets the start flag in the control register. The sequencer drives the slots in order, one clock each. It holds the bus idle for the programmed wait after each slot. When the list is exhausted it clears the valid flag, and software polls for that. Software then writes the done flag, which is the signal that normal operation may begin.

Top module: `dram_init_seq`

## Requirements
- R1: Under reset the pins are idle: cs_n, ras_n, cas_n and we_n are high, cke is low, and ba and addr are zero. issue_valid and init_done are low.
- R2: Register writes use reg_addr as follows. 0x00 is the control register: bit 0 is start and bit 1 is done. 0x01 is the issue register: bits 3:0 hold the last slot index and bit 4 is valid. 0x10+i is the command word of slot i. 0x20+i is the parameter word of slot i.
- R3: A sequence begins at the first clock edge at which valid and start are both held. Slot 0 is driven in the cycle that follows that edge.
- R4: A slot drives its pins from these fields. Command word bit 8 drives cs_n, bit 9 ras_n, bit 10 cas_n, bit 11 we_n and bit 12 cke. Command word bits 26:24 drive ba. Parameter word bits 10:0 drive addr. For example, 0x00FFF401 is precharge, 0x00FFF801 is refresh, 0x00FFF001 is mode load, 0x00FFFFFF is idle with cke high, and 0x00FFEFFE is idle with cke low.
- R5: Slots are driven strictly in order, from 0 up to and including the last index. Each slot's pattern lasts exactly one cycle.
- R6: The next slot is driven D+2 cycles after the previous one, where D is parameter word bits 31:11. The shortest spacing is therefore 2 cycles.
- R7: In every cycle in which no slot is being driven, the four strobes are high and ba and addr are zero. cke keeps the level of the last slot driven, or low if no slot has been driven since reset.
- R8: valid clears D+2 cycles after the last slot is driven, where D is that slot's delay field. No further slot is driven after that.
- R9: A write to the issue register is ignored while a sequence runs, including on the edge where the sequence starts.
- R10: Setting valid while start is clear drives nothing. A later write of start begins the sequence.
- R11: init_done follows the done bit. A write to the done bit is ignored while a sequence is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register or slot write strobe |
| reg_addr | input | 6 | Write address (see R2) |
| reg_wdata | input | 32 | Write data |
| dram_cke | output | 1 | Clock enable to the DRAM |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_ba | output | 3 | Bank address |
| dram_addr | output | 11 | Address / mode value |
| issue_valid | output | 1 | Issue register valid flag; cleared by hardware at the end of a sequence |
| init_done | output | 1 | Done flag from the control register |

## Verification
The bench aims at the off-by-one points of the wait counter. These are the shortest spacing of 2 cycles, a 300-cycle wait, and the gap between the last slot and the clearing of valid. A counter loaded with the wrong value shifts every later slot and so fails the per-cycle comparison. It runs a single-slot list and a full sixteen-slot list, where a design with a wrong end test would stop one slot early or wrap back to slot 0. It sets valid before start, and it writes the issue and done registers in the middle of a run. A design that starts early, that accepts a new last index mid-run, or that raises init_done too soon is caught by the cycle compare and by the counts of issued commands. A final cke-low slot checks that cke holds its level once the list has finished.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;
  localparam int CMD_W     = 32;
  localparam int BA_W      = 3;
  localparam int MODE_W    = 11;
  localparam int DLY_W     = CMD_W - MODE_W;
  localparam int CNT_W     = DLY_W + 1;
  localparam int PIN_LSB   = 8;   // cs_n, ras_n, cas_n, we_n upward from here
  localparam int CKE_BIT   = 12;
  localparam int BA_LSB    = 24;
  localparam int VALID_BIT = 4;   // valid flag position in the issue register
  localparam logic [CMD_W-1:0] IDLE_WORD = 32'h00FF_FFFF;

  typedef struct packed {
    logic            cke;
    logic            cs_n;
    logic            ras_n;
    logic            cas_n;
    logic            we_n;
    logic [BA_W-1:0] ba;
    logic [MODE_W-1:0] addr;
  } pins_t;

  // Pin pattern for one slot.
  function automatic pins_t slot_pins(input logic [CMD_W-1:0] cmd,
                                      input logic [CMD_W-1:0] prm);
    pins_t p;
    p.cke   = cmd[CKE_BIT];
    p.cs_n  = cmd[PIN_LSB];
    p.ras_n = cmd[PIN_LSB+1];
    p.cas_n = cmd[PIN_LSB+2];
    p.we_n  = cmd[PIN_LSB+3];
    p.ba    = cmd[BA_LSB +: BA_W];
    p.addr  = prm[MODE_W-1:0];
    return p;
  endfunction

  // Idle bus: strobes high, ba and addr zero, cke held.
  function automatic pins_t idle_pins(input logic cke);
    pins_t p;
    p       = '1;
    p.cke   = cke;
    p.ba    = '0;
    p.addr  = '0;
    return p;
  endfunction

  // The slots are spaced field+2 cycles apart. The issue cycle and the
  // reload edge take up two of those cycles, so the counter starts at field+1.
  function automatic logic [CNT_W-1:0] wait_load(input logic [CMD_W-1:0] prm);
    return {1'b0, prm[CMD_W-1:MODE_W]} + CNT_W'(1);
  endfunction
endpackage

// File: rtl/dram_init_slots.sv
module dram_init_slots
  import dram_init_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_AW  = $clog2(NUM_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_cmd,
  input  logic               wr_prm,
  input  logic [SLOT_AW-1:0] wr_idx,
  input  logic [CMD_W-1:0]   wr_data,
  input  logic [SLOT_AW-1:0] rd_idx,
  output logic [CMD_W-1:0]   rd_cmd,
  output logic [CMD_W-1:0]   rd_prm
);
  logic [CMD_W-1:0] cmd_mem [NUM_SLOTS];
  logic [CMD_W-1:0] prm_mem [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmd_mem[s] <= IDLE_WORD;
        prm_mem[s] <= '0;
      end else begin
        if (wr_cmd && wr_idx == SLOT_AW'(s)) cmd_mem[s] <= wr_data;
        if (wr_prm && wr_idx == SLOT_AW'(s)) prm_mem[s] <= wr_data;
      end
    end
  end

  assign rd_cmd = cmd_mem[rd_idx];
  assign rd_prm = prm_mem[rd_idx];
endmodule

// File: rtl/dram_init_regs.sv
module dram_init_regs
  import dram_init_pkg::*;
#(
  parameter int SLOT_AW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctl,
  input  logic               wr_iss,
  input  logic [VALID_BIT:0] wdata,
  input  logic               busy,
  input  logic               go,
  input  logic               seq_done,
  output logic               start_q,
  output logic               done_q,
  output logic               valid_q,
  output logic [SLOT_AW-1:0] last_q
);
  logic iss_take;
  assign iss_take = wr_iss && !busy && !go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      last_q  <= '0;
    end else begin
      if (wr_ctl) begin
        start_q <= wdata[0];
        if (!busy) done_q <= wdata[1];
      end
      if (seq_done) begin
        valid_q <= 1'b0;
      end else if (iss_take) begin
        valid_q <= wdata[VALID_BIT];
        last_q  <= wdata[SLOT_AW-1:0];
      end
    end
  end

  AST_VALID_CLEAR_BY_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(valid_q) && $past(busy)) |-> $past(seq_done)); // R8
  AST_ISSUE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_done) |=> (valid_q && $stable(last_q))); // R9
  AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(done_q)); // R11
endmodule

// File: rtl/dram_init_sequencer.sv
module dram_init_sequencer
  import dram_init_pkg::*;
#(
  parameter int SLOT_AW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_valid,
  input  logic               init_start,
  input  logic [SLOT_AW-1:0] last_idx,
  output logic [SLOT_AW-1:0] rd_idx,
  input  logic [CMD_W-1:0]   rd_cmd,
  input  logic [CMD_W-1:0]   rd_prm,
  output logic               busy,
  output logic               go,
  output logic               seq_done,
  output pins_t              pins
);
  logic               busy_q;
  logic [SLOT_AW-1:0] idx_q;
  logic [CNT_W-1:0]   cnt_q;
  pins_t              pins_q;
  logic               step;

  assign go       = issue_valid && init_start && !busy_q;
  assign step     = busy_q && (cnt_q == '0);
  assign seq_done = step && (idx_q == last_idx);
  assign rd_idx   = busy_q ? idx_q + SLOT_AW'(1) : '0;
  assign busy     = busy_q;
  assign pins     = pins_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
      pins_q <= idle_pins(1'b0);
    end else if (go) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      cnt_q  <= wait_load(rd_prm);
      pins_q <= slot_pins(rd_cmd, rd_prm);
    end else if (seq_done) begin
      busy_q <= 1'b0;
      pins_q <= idle_pins(pins_q.cke);
    end else if (step) begin
      idx_q  <= rd_idx;
      cnt_q  <= wait_load(rd_prm);
      pins_q <= slot_pins(rd_cmd, rd_prm);
    end else if (busy_q) begin
      cnt_q  <= cnt_q - CNT_W'(1);
      pins_q <= idle_pins(pins_q.cke);
    end
  end

  AST_START_NEEDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(issue_valid && init_start)); // R3
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_q.cs_n |=> pins_q.cs_n); // R5
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q <= last_idx)); // R5
  AST_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (pins_q.cs_n && pins_q.ras_n && pins_q.cas_n && pins_q.we_n)); // R7
  AST_CKE_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && $past(!busy_q)) |-> $stable(pins_q.cke)); // R7
endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dram_init_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_AW  = $clog2(NUM_SLOTS),
  localparam int AW       = SLOT_AW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [CMD_W-1:0]  reg_wdata,
  output logic              dram_cke,
  output logic              dram_cs_n,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [BA_W-1:0]   dram_ba,
  output logic [MODE_W-1:0] dram_addr,
  output logic              issue_valid,
  output logic              init_done
);
  logic [1:0]         region;
  logic               wr_cmd, wr_prm, wr_ctl, wr_iss;
  logic [SLOT_AW-1:0] rd_idx, last_idx;
  logic [CMD_W-1:0]   rd_cmd, rd_prm;
  logic               busy, go, seq_done, init_start;
  pins_t              pins;

  assign region = reg_addr[AW-1 -: 2];
  assign wr_cmd = reg_wr && region == 2'b01;
  assign wr_prm = reg_wr && region == 2'b10;
  assign wr_ctl = reg_wr && region == 2'b00 && !reg_addr[0];
  assign wr_iss = reg_wr && region == 2'b00 &&  reg_addr[0];

  dram_init_slots #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
    .clk, .rst_n, .wr_cmd, .wr_prm,
    .wr_idx(reg_addr[SLOT_AW-1:0]), .wr_data(reg_wdata),
    .rd_idx, .rd_cmd, .rd_prm
  );

  dram_init_regs #(.SLOT_AW(SLOT_AW)) u_regs (
    .clk, .rst_n, .wr_ctl, .wr_iss, .wdata(reg_wdata[VALID_BIT:0]),
    .busy, .go, .seq_done,
    .start_q(init_start), .done_q(init_done), .valid_q(issue_valid), .last_q(last_idx)
  );

  dram_init_sequencer #(.SLOT_AW(SLOT_AW)) u_seq (
    .clk, .rst_n, .issue_valid, .init_start, .last_idx,
    .rd_idx, .rd_cmd, .rd_prm, .busy, .go, .seq_done, .pins
  );

  assign dram_cke   = pins.cke;
  assign dram_cs_n  = pins.cs_n;
  assign dram_ras_n = pins.ras_n;
  assign dram_cas_n = pins.cas_n;
  assign dram_we_n  = pins.we_n;
  assign dram_ba    = pins.ba;
  assign dram_addr  = pins.addr;
endmodule

// File: tb/test_dram_init_seq.sv
module test_dram_init_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        dram_cke, dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n;
  logic [2:0]  dram_ba;
  logic [10:0] dram_addr;
  logic        issue_valid, init_done;

  dram_init_seq i_dram_init_seq (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata,
    .dram_cke, .dram_cs_n, .dram_ras_n, .dram_cas_n, .dram_we_n,
    .dram_ba, .dram_addr, .issue_valid, .init_done
  );

  always #5 clk = ~clk;   // 100 MHz

  int    n_chk = 0, n_bad = 0, n_cmds = 0, cyc = 0;
  string tag = "R1";
  bit    cmp_en = 1'b0;

  // Reference model
  logic [31:0] m_cmd [16];
  logic [31:0] m_prm [16];
  logic [18:0] m_q [$];
  logic [18:0] m_exp;
  logic        m_valid, m_start, m_done, m_run, m_cke;
  int          m_last;

  // R4: {cke, cs_n, ras_n, cas_n, we_n, ba, addr}
  function automatic logic [18:0] expect_slot(logic [31:0] c, logic [31:0] p);
    return {c[12], c[8], c[9], c[10], c[11], c[26:24], p[10:0]};
  endfunction
  function automatic logic [18:0] expect_idle(logic k);
    return {k, 4'hF, 3'b000, 11'h000};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 16; s++) begin m_cmd[s] = 32'h00FF_FFFF; m_prm[s] = 0; end
      m_q.delete();
      m_valid = 0; m_start = 0; m_done = 0; m_run = 0; m_cke = 0; m_last = 0;
      m_exp = expect_idle(1'b0);
    end else begin
      bit pre_run, pre_go;
      pre_run = m_run;
      pre_go  = m_valid && m_start && !m_run;
      if (pre_go) begin
        for (int s = 0; s <= m_last; s++) begin
          m_q.push_back(expect_slot(m_cmd[s], m_prm[s]));
          for (int w = 0; w <= int'(m_prm[s][31:11]); w++)
            m_q.push_back(expect_idle(m_cmd[s][12]));
        end
        m_run = 1;
      end
      if (m_run) begin
        if (m_q.size() > 0) begin
          m_exp = m_q.pop_front();
          m_cke = m_exp[18];
        end else begin
          m_run = 0; m_valid = 0; m_exp = expect_idle(m_cke);
        end
      end else begin
        m_exp = expect_idle(m_cke);
      end
      if (reg_wr) begin
        case (reg_addr[5:4])
          2'b01: m_cmd[reg_addr[3:0]] = reg_wdata;
          2'b10: m_prm[reg_addr[3:0]] = reg_wdata;
          2'b00: if (!reg_addr[0]) begin
                   m_start = reg_wdata[0];
                   if (!pre_run) m_done = reg_wdata[1];
                 end else if (!pre_run && !pre_go) begin
                   m_valid = reg_wdata[4];
                   m_last  = int'(reg_wdata[3:0]);
                 end
          default: ;
        endcase
      end
    end
  end

  // Cycle compare against the model, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      logic [20:0] act, exp;
      act = {dram_cke, dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n, dram_ba, dram_addr,
             issue_valid, init_done};
      exp = {m_exp, m_valid, m_done};
      n_chk++;
      if (act !== exp) begin
        n_bad++;
        $display("FAIL %s cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
      end
    end
    if (rst_n && !dram_cs_n) n_cmds++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 40000) begin
      n_bad++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic load(int s, logic [31:0] c, int dly, logic [10:0] ad);
    wr(6'h10 + 6'(s), c);
    wr(6'h20 + 6'(s), (32'(dly) << 11) | 32'(ad));
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (!issue_valid) break;
    end
  endtask

  localparam logic [31:0] NOP_HI = 32'h00FF_FFFF, PRE = 32'h00FF_F401,
                          REF = 32'h00FF_F801, LMR = 32'h00FF_F001, CKE_LO = 32'h00FF_EFFE;

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pins", {dram_cke, dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n, dram_ba, dram_addr},
        {1'b0, 4'hF, 3'd0, 11'd0});
    chk("R1 flags", {issue_valid, init_done}, 2'b00);
    rst_n = 1'b1;
    cmp_en = 1'b1;

    // R10, R2: valid without start does nothing
    tag = "R2/R10";
    load(0, NOP_HI, 3, 11'h000);
    load(1, PRE, 0, 11'h400);
    load(2, LMR | (32'd2 << 24), 1, 11'h123);
    base = n_cmds;
    wr(6'h01, 32'h12);
    repeat (8) @(negedge clk);
    chk("R10 valid held", issue_valid, 1);
    chk("R10 no command", n_cmds - base, 0);
    // R3, R5, R6: start begins the list; mid-run writes are dropped (R9, R11)
    tag = "R3/R5/R6/R9/R11";
    wr(6'h00, 32'h1);
    repeat (2) @(negedge clk);
    wr(6'h01, 32'h1F);
    wr(6'h00, 32'h3);
    chk("R9 valid kept mid-run", issue_valid, 1);
    wait_idle();
    chk("R8 valid cleared", issue_valid, 0);
    chk("R11 done ignored mid-run", init_done, 0);
    chk("R5 command count", n_cmds - base, 2);
    tag = "R11";
    wr(6'h00, 32'h2);
    chk("R11 done written", init_done, 1);

    // R4, R6, R7: a full init list ending in cke low
    tag = "R4/R6/R7";
    load(0, NOP_HI, 38, 11'h000);
    load(1, PRE, 1, 11'h400);
    load(2, LMR | (32'd2 << 24), 0, 11'h000);
    load(3, LMR | (32'd3 << 24), 0, 11'h000);
    load(4, LMR | (32'd1 << 24), 0, 11'h040);
    load(5, LMR, 0, 11'h153);
    load(6, PRE, 1, 11'h400);
    load(7, REF, 11, 11'h000);
    load(8, REF, 11, 11'h000);
    load(9, LMR, 0, 11'h053);
    load(10, LMR | (32'd1 << 24), 0, 11'h3C0);
    load(11, CKE_LO, 5, 11'h000);
    wr(6'h00, 32'h3);
    base = n_cmds;
    wr(6'h01, 32'h1B);
    wait_idle();
    chk("R5 full list count", n_cmds - base, 10);
    repeat (4) @(negedge clk);
    chk("R7 cke held low", dram_cke, 0);
    chk("R8 valid cleared", issue_valid, 0);

    // R5, R6: single slot with a long wait
    tag = "R5/R6 single";
    load(0, REF, 300, 11'h000);
    base = n_cmds;
    wr(6'h01, 32'h10);
    repeat (200) @(negedge clk);
    chk("R6 long wait valid", issue_valid, 1);
    wait_idle();
    chk("R5 single count", n_cmds - base, 1);
    chk("R7 cke from refresh", dram_cke, 1);

    // R5: all sixteen slots
    tag = "R5/R6 sixteen";
    for (int s = 0; s < 16; s++) load(s, REF | (32'(s % 8) << 24), s % 3, 11'(s));
    base = n_cmds;
    wr(6'h01, 32'h1F);
    wait_idle();
    chk("R5 sixteen count", n_cmds - base, 16);
    repeat (5) @(negedge clk);
    chk("R8 no restart", n_cmds - base, 16);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule